// File: doc/BRIEF.md
# Banked Host Register File with Identification Signature

This block is the byte-wide register front end of a network controller. A host reaches sixteen offsets through a simple read/write strobe interface. Which physical registers those offsets reach depends on a bank number. Software sets the bank by writing offset 0, and that write also carries a command opcode. Offset 0 is the command register in every bank, so software can always move to another bank from wherever it is.

Bank 0 holds the command, interrupt status, identification and interrupt mask registers. Bank 1 holds four buffer limit page registers. Bank 2 holds three configuration bytes and the six bytes of the station address.

The identification register has a fixed signature in its middle bits and a two-bit counter in its top bits. The counter steps on every read. Probe software can therefore tell the device apart from plain memory, which would return the same value twice.

Interrupt status flags are set by event inputs and are cleared by writing one to them. A full reset opcode returns every register to its reset value. The block latches each opcode and presents it to the datapath, which is outside this block.

Top module: `nic_bank_regs`

## Requirements
- R1: After rst_n is deasserted, the state is as follows. The bank is 0. Status, mask, configuration and station address registers are zero. The identification counter is 0. The limit registers at bank 1 offsets 8, 9, 10 and 11 hold RXLO_RST, RXHI_RST, TXLO_RST and TXHI_RST (defaults 0x00, 0x5F, 0x60, 0x7F). cmd_op, cmd_stb and host_rdata are zero.
- R2: A write to offset 0 in any bank loads the bank from data bits 7:6. The values 00, 01 and 10 select bank 0, 1 and 2. The value 11 leaves the bank unchanged. A read of offset 0 returns the bank in bits 7:6 and zero in bits 5:0.
- R3: Bits 5:0 of every write to offset 0 appear on cmd_op in the cycle after the write. In that same cycle cmd_stb is high. cmd_stb lasts one cycle, and cmd_op then holds its value.
- R4: In bank 0, reading offset 2 returns bits 5 and 2 as one and bits 4, 3, 1 and 0 as zero, so the value masked with 0x2C equals 0x24. Writes to this offset have no effect.
- R5: The identification counter is in bits 7:6. It reads 00 on the first read after reset, advances by one (0x40) after each read of the identification register, and wraps from 11 to 00. Reads of other offsets and writes do not advance it.
- R6: The status register is at bank 0 offset 1. Bit 0 is receive stop, bit 1 is receive, bit 2 is transmit and bit 3 is execution. A one-cycle pulse on evt_rx_stop, evt_rx, evt_tx or evt_exec sets the matching bit, and the bit stays set. Bits 7:4 read zero.
- R7: Writing the status register clears exactly the bits written as one, so writing 0x0F clears all flags. If an event arrives in the same cycle as a clear of its bit, the bit ends up set.
- R8: The interrupt mask register is at bank 0 offset 3. It stores data bits 3:0. Bit 0 masks receive stop, bit 1 receive, bit 2 transmit and bit 3 execution. Bits 7:4 read zero.
- R9: The bank 1 limit registers at offsets 8 to 11 are full-byte read/write. So are the bank 2 configuration registers at offsets 1 to 3 and the station address bytes at offsets 4 to 9. Registers at the same offset in different banks are independent.
- R10: Offsets not listed in R2 to R9 read zero, and writes to them have no effect.
- R11: A write to offset 0 with opcode 0x0E performs a full reset. It returns all registers and the identification counter to their R1 values and selects bank 0, whatever bits 7:6 hold. The opcode is still reported on cmd_op with cmd_stb.
- R12: host_rdata is loaded on the clock edge that samples host_rd, so it is valid in the following cycle. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Register offset |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| evt_rx_stop | input | 1 | Receive-stop event pulse |
| evt_rx | input | 1 | Receive event pulse |
| evt_tx | input | 1 | Transmit event pulse |
| evt_exec | input | 1 | Execution event pulse |
| cmd_op | output | 6 | Last latched command opcode |
| cmd_stb | output | 1 | One-cycle pulse for a new opcode |

## Verification
Every result arrives one clock edge after its cause:
- Read data appears on the edge that samples host_rd.
- cmd_op and cmd_stb follow the edge that samples an offset-0 write.
- A new bank, a status set or clear, or a stored byte can be seen by the read issued in the next cycle.

The bench drives each strobe or event on a falling edge and drops it on the next falling edge. It samples outputs on that second falling edge, half a cycle after the only edge that could have changed them. Identification reads are counted in the bench, so the expected counter value follows from the number of reads issued since reset or since a full reset.

// File: rtl/nic_bank_regs.sv
module nic_bank_regs #(
  parameter logic [7:0] RXLO_RST = 8'h00,
  parameter logic [7:0] RXHI_RST = 8'h5F,
  parameter logic [7:0] TXLO_RST = 8'h60,
  parameter logic [7:0] TXHI_RST = 8'h7F,
  parameter logic [5:0] OP_FULL_RESET = 6'h0E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] host_addr,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       evt_rx_stop,
  input  logic       evt_rx,
  input  logic       evt_tx,
  input  logic       evt_exec,
  output logic [5:0] cmd_op,
  output logic       cmd_stb
);

  localparam logic [5:0] ID_LOW    = 6'b100100;
  localparam logic [7:0] ID_MASK   = 8'h2C;
  localparam logic [7:0] ID_MATCH  = 8'h24;
  localparam int         NLIM      = 4;
  localparam int         NCFG      = 3;
  localparam int         NSTA      = 6;

  logic [1:0] bank_q, id_cnt_q;
  logic [3:0] stat_q, mask_q;
  logic [5:0] op_q;
  logic       stb_q;
  logic [7:0] rdata_q, rd_mux;
  logic [7:0] lim_q [NLIM];
  logic [7:0] cfg_q [NCFG];
  logic [7:0] sta_q [NSTA];

  wire b0 = (bank_q == 2'd0);
  wire b1 = (bank_q == 2'd1);
  wire b2 = (bank_q == 2'd2);

  wire wr_cmd   = host_wr && (host_addr == 4'd0);
  wire full_rst = wr_cmd && (host_wdata[5:0] == OP_FULL_RESET);
  wire rd_id    = host_rd && b0 && (host_addr == 4'd2);

  wire is_lim = (host_addr[3:2] == 2'b10);
  wire is_cfg = (host_addr >= 4'd1) && (host_addr <= 4'd3);
  wire is_sta = (host_addr >= 4'd4) && (host_addr <= 4'd9);
  wire [1:0] cfg_idx = host_addr[1:0] - 2'd1;
  wire [2:0] sta_idx = host_addr[2:0] - 3'd4;

  wire [3:0] stat_set = {evt_exec, evt_tx, evt_rx, evt_rx_stop};
  wire [3:0] stat_clr = (host_wr && b0 && host_addr == 4'd1) ? host_wdata[3:0] : 4'd0;
  wire [7:0] id_val   = {id_cnt_q, ID_LOW};

  always_comb begin
    rd_mux = 8'd0;
    if (host_addr == 4'd0) rd_mux = {bank_q, 6'd0};
    else if (b0) begin
      case (host_addr)
        4'd1: rd_mux = {4'd0, stat_q};
        4'd2: rd_mux = id_val;
        4'd3: rd_mux = {4'd0, mask_q};
        default: rd_mux = 8'd0;
      endcase
    end
    else if (b1) begin
      if (is_lim) rd_mux = lim_q[host_addr[1:0]];
    end
    else if (b2) begin
      if (is_cfg) rd_mux = cfg_q[cfg_idx];
      else if (is_sta) rd_mux = sta_q[sta_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q   <= 2'd0;
      id_cnt_q <= 2'd0;
      stat_q   <= 4'd0;
      mask_q   <= 4'd0;
      op_q     <= 6'd0;
      stb_q    <= 1'b0;
      rdata_q  <= 8'd0;
      lim_q[0] <= RXLO_RST;
      lim_q[1] <= RXHI_RST;
      lim_q[2] <= TXLO_RST;
      lim_q[3] <= TXHI_RST;
      for (int i = 0; i < NCFG; i++) cfg_q[i] <= 8'd0;
      for (int i = 0; i < NSTA; i++) sta_q[i] <= 8'd0;
    end else begin
      stb_q <= wr_cmd;
      if (wr_cmd) op_q <= host_wdata[5:0];
      if (host_rd) rdata_q <= rd_mux;
      if (full_rst) begin
        bank_q   <= 2'd0;
        id_cnt_q <= 2'd0;
        stat_q   <= 4'd0;
        mask_q   <= 4'd0;
        lim_q[0] <= RXLO_RST;
        lim_q[1] <= RXHI_RST;
        lim_q[2] <= TXLO_RST;
        lim_q[3] <= TXHI_RST;
        for (int i = 0; i < NCFG; i++) cfg_q[i] <= 8'd0;
        for (int i = 0; i < NSTA; i++) sta_q[i] <= 8'd0;
      end else begin
        if (wr_cmd && host_wdata[7:6] != 2'b11) bank_q <= host_wdata[7:6];
        if (rd_id) id_cnt_q <= id_cnt_q + 2'd1;
        stat_q <= (stat_q & ~stat_clr) | stat_set;
        if (host_wr && b0 && host_addr == 4'd3) mask_q <= host_wdata[3:0];
        if (host_wr && b1 && is_lim) lim_q[host_addr[1:0]] <= host_wdata;
        if (host_wr && b2 && is_cfg) cfg_q[cfg_idx] <= host_wdata;
        if (host_wr && b2 && is_sta) sta_q[sta_idx] <= host_wdata;
      end
    end
  end

  assign host_rdata = rdata_q;
  assign cmd_op     = op_q;
  assign cmd_stb    = stb_q;

  a_r2_bank_legal: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q != 2'b11);

  a_r4_id_signature: assert property (@(posedge clk) disable iff (!rst_n)
    rd_id |=> ((host_rdata & ID_MASK) == ID_MATCH));

  a_r5_id_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_id && !full_rst) |=> $stable(id_cnt_q));

  a_r6_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_rst && stat_clr == 4'd0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_rst && stat_set != 4'd0) |=> ((stat_q & $past(stat_set)) == $past(stat_set)));

  a_r11_full_reset: assert property (@(posedge clk) disable iff (!rst_n)
    full_rst |=> (bank_q == 2'd0 && stat_q == 4'd0 && mask_q == 4'd0 && id_cnt_q == 2'd0 && cmd_stb));

endmodule

// File: tb/nic_bank_regs_tb_top.sv
module nic_bank_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] host_addr = 4'd0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       evt_rx_stop = 1'b0, evt_rx = 1'b0, evt_tx = 1'b0, evt_exec = 1'b0;
  logic [5:0] cmd_op;
  logic       cmd_stb;

  int  tests = 0, fails = 0;
  bit  done = 1'b0;
  logic [7:0] rv;
  logic       snap_stb;
  logic [5:0] snap_op;

  always #10 clk = ~clk;

  nic_bank_regs dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .evt_rx_stop(evt_rx_stop),
    .evt_rx(evt_rx), .evt_tx(evt_tx), .evt_exec(evt_exec), .cmd_op(cmd_op), .cmd_stb(cmd_stb)
  );

  // {write, addr, data, expected read value}
  localparam int NV = 34;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 4'd0,  8'h40, 8'h00}, {1'b1, 4'd8,  8'h12, 8'h00},
    {1'b1, 4'd9,  8'h5A, 8'h00}, {1'b1, 4'd10, 8'h66, 8'h00},
    {1'b1, 4'd11, 8'h7E, 8'h00}, {1'b0, 4'd8,  8'h00, 8'h12},
    {1'b0, 4'd9,  8'h00, 8'h5A}, {1'b0, 4'd10, 8'h00, 8'h66},
    {1'b0, 4'd11, 8'h00, 8'h7E}, {1'b0, 4'd3,  8'h00, 8'h00},
    {1'b0, 4'd0,  8'h00, 8'h40}, {1'b1, 4'd0,  8'h80, 8'h00},
    {1'b1, 4'd4,  8'h00, 8'h00}, {1'b1, 4'd5,  8'hAA, 8'h00},
    {1'b1, 4'd6,  8'h00, 8'h00}, {1'b1, 4'd7,  8'h12, 8'h00},
    {1'b1, 4'd8,  8'h34, 8'h00}, {1'b1, 4'd9,  8'h56, 8'h00},
    {1'b1, 4'd1,  8'hC3, 8'h00}, {1'b1, 4'd3,  8'h3F, 8'h00},
    {1'b1, 4'd12, 8'hFF, 8'h00}, {1'b0, 4'd5,  8'h00, 8'hAA},
    {1'b0, 4'd7,  8'h00, 8'h12}, {1'b0, 4'd9,  8'h00, 8'h56},
    {1'b0, 4'd1,  8'h00, 8'hC3}, {1'b0, 4'd3,  8'h00, 8'h3F},
    {1'b0, 4'd12, 8'h00, 8'h00}, {1'b0, 4'd0,  8'h00, 8'h80},
    {1'b1, 4'd0,  8'h00, 8'h00}, {1'b1, 4'd3,  8'hFF, 8'h00},
    {1'b0, 4'd3,  8'h00, 8'h0F}, {1'b0, 4'd8,  8'h00, 8'h00},
    {1'b1, 4'd0,  8'h40, 8'h00}, {1'b0, 4'd8,  8'h00, 8'h12}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    snap_stb = cmd_stb; snap_op = cmd_op;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cmd_op", {2'b0, cmd_op}, 8'h00);
    chk("R1 cmd_stb", {7'b0, cmd_stb}, 8'h00);
    chk("R1 rdata", host_rdata, 8'h00);
    rd(4'd0, rv); chk("R1 bank0", rv, 8'h00);
    rd(4'd1, rv); chk("R1 status", rv, 8'h00);
    rd(4'd3, rv); chk("R1 mask", rv, 8'h00);
    // R4 R5 identification signature and counter
    rd(4'd2, rv); chk("R5 id read1", rv, 8'h24);
    rd(4'd2, rv); chk("R5 id read2", rv, 8'h64);
    rd(4'd2, rv); chk("R5 id read3", rv, 8'hA4);
    rd(4'd2, rv); chk("R5 id read4", rv, 8'hE4);
    rd(4'd2, rv); chk("R5 id wrap", rv, 8'h24);
    rd(4'd1, rv);
    rd(4'd2, rv); chk("R5 other read no step", rv, 8'h64);
    wr(4'd2, 8'hFF);
    rd(4'd2, rv); chk("R4 write ignored", rv, 8'hA4);
    chk("R4 signature", rv & 8'h2C, 8'h24);
    // R1 limit defaults
    wr(4'd0, 8'h40);
    rd(4'd9, rv);  chk("R1 rx hi default", rv, 8'h5F);
    rd(4'd10, rv); chk("R1 tx lo default", rv, 8'h60);
    wr(4'd0, 8'h00);
    // R9 R10 R2 R8 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) wr(VEC[i][19:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][19:16], rv);
        chk($sformatf("R9 R10 R2 R8 vector %0d", i), rv, VEC[i][7:0]);
      end
    end
    // R3 opcode latch, R2 reserved bank code
    wr(4'd0, 8'h48);
    chk("R3 stb high", {7'b0, snap_stb}, 8'h01);
    chk("R3 opcode", {2'b0, snap_op}, 8'h08);
    @(negedge clk);
    chk("R3 stb one cycle", {7'b0, cmd_stb}, 8'h00);
    chk("R3 opcode held", {2'b0, cmd_op}, 8'h08);
    wr(4'd0, 8'hC4);
    chk("R3 opcode with bank 11", {2'b0, snap_op}, 8'h04);
    rd(4'd0, rv); chk("R2 code 11 keeps bank", rv, 8'h40);
    // R6 R7 R12 status flags
    wr(4'd0, 8'h00);
    @(negedge clk); evt_rx = 1'b1;
    @(negedge clk); evt_rx = 1'b0;
    rd(4'd1, rv); chk("R6 rx flag", rv, 8'h02);
    @(negedge clk); evt_tx = 1'b1; evt_exec = 1'b1;
    @(negedge clk); evt_tx = 1'b0; evt_exec = 1'b0;
    rd(4'd1, rv); chk("R6 tx exec flags", rv, 8'h0E);
    @(negedge clk); evt_rx_stop = 1'b1;
    @(negedge clk); evt_rx_stop = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 rdata held", host_rdata, 8'h0E);
    rd(4'd1, rv); chk("R6 sticky all", rv, 8'h0F);
    wr(4'd1, 8'h02);
    rd(4'd1, rv); chk("R7 clear one bit", rv, 8'h0D);
    wr(4'd1, 8'h0F);
    rd(4'd1, rv); chk("R7 clear all", rv, 8'h00);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 4'd1; host_wdata = 8'h04; evt_tx = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; evt_tx = 1'b0;
    rd(4'd1, rv); chk("R7 set beats clear", rv, 8'h04);
    wr(4'd3, 8'hA5);
    rd(4'd3, rv); chk("R8 mask low bits", rv, 8'h05);
    // R11 full reset
    rd(4'd2, rv);
    wr(4'd0, 8'h8E);
    chk("R11 opcode reported", {2'b0, snap_op}, 8'h0E);
    chk("R11 stb", {7'b0, snap_stb}, 8'h01);
    rd(4'd0, rv); chk("R11 bank 0", rv, 8'h00);
    rd(4'd1, rv); chk("R11 status", rv, 8'h00);
    rd(4'd3, rv); chk("R11 mask", rv, 8'h00);
    rd(4'd2, rv); chk("R11 id counter", rv, 8'h24);
    wr(4'd0, 8'h40);
    rd(4'd8, rv); chk("R11 rx lo limit", rv, RXLO_EXP);
    rd(4'd9, rv); chk("R11 rx hi limit", rv, 8'h5F);
    wr(4'd0, 8'h80);
    rd(4'd5, rv); chk("R11 station byte", rv, 8'h00);
    rd(4'd1, rv); chk("R11 config byte", rv, 8'h00);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  localparam logic [7:0] RXLO_EXP = 8'h00;
endmodule